// File: doc/BRIEF.md
# Endian Conversion Byte Swap Unit

This block carries out the byte-order conversion step of a register-only ALU operation. It takes the current value of a 64-bit destination register and rewrites it according to three decoded fields: a class bit that picks the 32-bit or the 64-bit operation class, a one-bit order field, and a width taken from the immediate. No second operand is involved. The host is assumed little-endian.

In the 32-bit class the order field picks the target byte order. The low-order setting converts to or from little endian, which on this host only keeps the selected low bits. The high-order setting converts to or from big endian, which reverses the bytes of the selected low bits. In the 64-bit class the bytes are always reversed, and the order field must be zero. A width other than 16, 32 or 64, or a set order field in the 64-bit class, is flagged as illegal, and the value is passed through unchanged. The result can be taken straight from the logic or through one output register, chosen by a parameter. The default is registered.

Top module: `endian_swap_unit`

## Requirements
- R1: `illegal_o` is 1 when `width_i` is not 16, 32 or 64. Otherwise the width on its own does not raise it.
- R2: `illegal_o` is 1 when `cls64_i`=1 and `to_be_i`=1 (order field value 0x08 in the 64-bit class), whatever the width.
- R3: When the encoding is illegal, `data_o` equals `data_i` unchanged.
- R4: With `cls64_i`=0, `to_be_i`=0 and width 16 or 32, `data_o` holds the low 16 or 32 bits of `data_i` and zeros above.
- R5: With `cls64_i`=0, `to_be_i`=0 and width 64, `data_o` equals `data_i`.
- R6: With `cls64_i`=0, `to_be_i`=1 and a legal width W, byte k of `data_o` (bits 8k+7..8k) equals byte W/8-1-k of `data_i` for k < W/8. All bits from W upward are zero.
- R7: With `cls64_i`=1, `to_be_i`=0 and a legal width W, `data_o` is the byte reversal of the low W bits of `data_i` with zero fill, as in R6.
- R8: With REG_OUT=1 (the default), the outputs reflect the inputs sampled at the previous rising clock edge. While `rst_ni` is low, `data_o` and `illegal_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cls64_i | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| to_be_i | input | 1 | Order field: 0 = little endian (0x00), 1 = big endian (0x08) |
| width_i | input | 32 | Immediate carrying the swap width in bits |
| data_i | input | 64 | Destination register value |
| data_o | output | 64 | Converted value |
| illegal_o | output | 1 | Illegal encoding flag |

## Verification
Two functions can act on the same operation: illegal-encoding detection and the unconditional swap of the 64-bit class. Both apply when the 64-bit class arrives with the order field set and a legal width. The bench drives this case directly, and also reaches it through random class, order and width draws. It is judged correct only if the flag rises and the value passes through unswapped. A second overlap is a bad width combined with the 64-bit class and the order field clear. That case must also pass the value through rather than swap any part of it.

// File: rtl/bswap_pkg.sv
package bswap_pkg;
  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_TRUNC = 2'd1,
    MODE_SWAP  = 2'd2
  } bswap_mode_e;
  localparam int unsigned NUM_SZ = 3;   // 16, 32, 64
  localparam int unsigned MIN_W  = 16;
endpackage

// File: rtl/bswap_decode.sv
module bswap_decode
  import bswap_pkg::*;
#(
  parameter int unsigned IMM_W = 32
) (
  input  logic               cls64_i,
  input  logic               to_be_i,
  input  logic [IMM_W-1:0]   width_i,
  output logic [NUM_SZ-1:0]  sz_hot_o,
  output bswap_mode_e        mode_o,
  output logic               illegal_o
);
  for (genvar s = 0; s < NUM_SZ; s++) begin : g_sz
    assign sz_hot_o[s] = (width_i == IMM_W'(MIN_W << s));
  end

  logic bad_width, bad_src;
  assign bad_width = ~|sz_hot_o;
  assign bad_src   = cls64_i & to_be_i;
  assign illegal_o = bad_width | bad_src;

  always_comb begin
    if (illegal_o)                 mode_o = MODE_PASS;
    else if (cls64_i || to_be_i)   mode_o = MODE_SWAP;
    else                           mode_o = MODE_TRUNC;
  end
endmodule

// File: rtl/bswap_core.sv
module bswap_core
  import bswap_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [NUM_SZ-1:0] sz_hot_i,
  input  bswap_mode_e       mode_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned NB = DATA_W / 8;

  logic [DATA_W-1:0] swp [NUM_SZ];
  logic [DATA_W-1:0] trn [NUM_SZ];

  for (genvar s = 0; s < NUM_SZ; s++) begin : g_sz
    localparam int unsigned NBY = NB >> (NUM_SZ - 1 - s);
    for (genvar b = 0; b < NB; b++) begin : g_byte
      if (b < NBY) begin : g_in
        assign swp[s][b*8 +: 8] = data_i[(NBY-1-b)*8 +: 8];
        assign trn[s][b*8 +: 8] = data_i[b*8 +: 8];
      end else begin : g_zero
        assign swp[s][b*8 +: 8] = 8'h00;
        assign trn[s][b*8 +: 8] = 8'h00;
      end
    end
  end

  always_comb begin
    data_o = data_i;
    for (int s = 0; s < NUM_SZ; s++) begin
      if (sz_hot_i[s]) begin
        unique case (mode_i)
          MODE_SWAP:  data_o = swp[s];
          MODE_TRUNC: data_o = trn[s];
          default:    data_o = data_i;
        endcase
      end
    end
  end
endmodule

// File: rtl/endian_swap_unit.sv
module endian_swap_unit
  import bswap_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned IMM_W   = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cls64_i,
  input  logic              to_be_i,
  input  logic [IMM_W-1:0]  width_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              illegal_o
);
  logic [NUM_SZ-1:0] sz_hot;
  bswap_mode_e       mode;
  logic              ill_c;
  logic [DATA_W-1:0] res_c;

  bswap_decode #(.IMM_W(IMM_W)) u_dec (
    .cls64_i   (cls64_i),
    .to_be_i   (to_be_i),
    .width_i   (width_i),
    .sz_hot_o  (sz_hot),
    .mode_o    (mode),
    .illegal_o (ill_c)
  );

  bswap_core #(.DATA_W(DATA_W)) u_core (
    .data_i   (data_i),
    .sz_hot_i (sz_hot),
    .mode_i   (mode),
    .data_o   (res_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o    <= '0;
        illegal_o <= 1'b0;
      end else begin
        data_o    <= res_c;
        illegal_o <= ill_c;
      end
    end
  end else begin : g_comb
    assign data_o    = res_c;
    assign illegal_o = ill_c;
  end
endmodule

// File: rtl/endian_swap_chk.sv
module endian_swap_chk #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned IMM_W   = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cls64_i,
  input logic              to_be_i,
  input logic [IMM_W-1:0]  width_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              illegal_o
);
  logic              armed;
  logic              c64, tbe;
  logic [IMM_W-1:0]  wid;
  logic [DATA_W-1:0] din;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        armed <= 1'b0; c64 <= 1'b0; tbe <= 1'b0; wid <= '0; din <= '0;
      end else begin
        armed <= 1'b1; c64 <= cls64_i; tbe <= to_be_i; wid <= width_i; din <= data_i;
      end
    end
  end else begin : g_comb
    assign armed = 1'b1;
    assign c64 = cls64_i; assign tbe = to_be_i; assign wid = width_i; assign din = data_i;
  end

  logic w16, w32, w64, legal_w;
  assign w16 = (wid == IMM_W'(16));
  assign w32 = (wid == IMM_W'(32));
  assign w64 = (wid == IMM_W'(64));
  assign legal_w = w16 | w32 | w64;

  assert_bad_width_R1: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !legal_w |-> illegal_o);
  assert_bad_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (c64 && tbe) |-> illegal_o);
  assert_legal_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (legal_w && !(c64 && tbe)) |-> !illegal_o);
  assert_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    illegal_o |-> (data_o == din));
  assert_trunc16_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (!c64 && !tbe && w16) |-> (data_o == {{(DATA_W-16){1'b0}}, din[15:0]}));
  assert_le64_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (!c64 && !tbe && w64) |-> (data_o == din));
  assert_be16_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (!c64 && tbe && w16) |-> (data_o == {{(DATA_W-16){1'b0}}, din[7:0], din[15:8]}));
  assert_sw32_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (c64 && !tbe && w32) |-> (data_o[DATA_W-1:32] == '0 && data_o[7:0] == din[31:24]));
  assert_reset_R8: assert property (@(posedge clk_i) !rst_ni |-> (data_o == '0 && !illegal_o));
endmodule

bind endian_swap_unit endian_swap_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .REG_OUT(REG_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cls64_i(cls64_i), .to_be_i(to_be_i),
  .width_i(width_i), .data_i(data_i), .data_o(data_o), .illegal_o(illegal_o)
);

// File: tb/tb_endian_swap_unit.sv
`timescale 1ns/1ps
module tb_endian_swap_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cls64_i = 1'b0;
  logic        to_be_i = 1'b0;
  logic [31:0] width_i = 32'd0;
  logic [63:0] data_i = 64'd0;
  logic [63:0] data_o;
  logic        illegal_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;   // 125 MHz

  endian_swap_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cls64_i(cls64_i), .to_be_i(to_be_i),
    .width_i(width_i), .data_i(data_i), .data_o(data_o), .illegal_o(illegal_o)
  );

  function automatic bit exp_ill(bit c, bit t, logic [31:0] w);
    return !(w == 32'd16 || w == 32'd32 || w == 32'd64) || (c && t);
  endfunction

  function automatic logic [63:0] exp_val(bit c, bit t, logic [31:0] w, logic [63:0] d);
    logic [63:0] r;
    int nb;
    if (exp_ill(c, t, w)) return d;
    nb = w / 8;
    r = '0;
    for (int k = 0; k < nb; k++) begin
      if (c || t) r[k*8 +: 8] = d[(nb-1-k)*8 +: 8];
      else        r[k*8 +: 8] = d[k*8 +: 8];
    end
    return r;
  endfunction

  function automatic string req_of(bit c, bit t, logic [31:0] w);
    if (c && t) return "R2";
    if (exp_ill(c, t, w)) return "R1/R3";
    if (c) return "R7";
    if (t) return "R6";
    if (w == 32'd64) return "R5";
    return "R4";
  endfunction

  task automatic check(string rq, logic [63:0] av, logic [63:0] ev, bit ai, bit ei);
    n_cmp++;
    if (av !== ev || ai !== ei) begin
      n_bad++;
      $display("FAIL %s: data=%h ill=%b expected data=%h ill=%b", rq, av, ai, ev, ei);
    end
  endtask

  task automatic apply(bit c, bit t, logic [31:0] w, logic [63:0] d);
    cls64_i = c; to_be_i = t; width_i = w; data_i = d;
    @(negedge clk_i);   // captured at the posedge in between (R8)
    check(req_of(c, t, w), data_o, exp_val(c, t, w, d), illegal_o, exp_ill(c, t, w));
  endtask

  initial begin
    logic [31:0] w;
    logic [63:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    cls64_i = 1'b1; to_be_i = 1'b0; width_i = 32'd64; data_i = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk_i);
    check("R8", data_o, 64'd0, illegal_o, 1'b0);   // reset holds outputs at zero
    rst_ni = 1'b1;

    d = 64'h0123_4567_89AB_CDEF;
    apply(0, 0, 16, d);                           // R4
    apply(0, 0, 32, d);                           // R4
    apply(0, 0, 64, d);                           // R5
    apply(0, 1, 16, d);                           // R6
    apply(0, 1, 32, d);                           // R6
    apply(0, 1, 64, d);                           // R6
    apply(1, 0, 16, d);                           // R7
    apply(1, 0, 64, d);                           // R7
    apply(1, 1, 32, d);                           // R2 overlaps swap
    apply(1, 0, 8, d);                            // R1 with 64-bit class
    apply(0, 1, 0, d);                            // R1
    apply(0, 0, 48, d);                           // R1/R3
    apply(0, 0, 32'h8000_0010, d);                // R1 upper imm bits

    // R8: latency, output follows the previous sample
    cls64_i = 0; to_be_i = 1; width_i = 32; data_i = 64'hAABB_CCDD_1122_3344;
    @(posedge clk_i); #1;
    data_i = 64'h0;
    @(negedge clk_i);
    check("R8", data_o, 64'h0000_0000_4433_2211, illegal_o, 1'b0);
    @(negedge clk_i);

    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 4))
        0: w = 32'd16;
        1: w = 32'd32;
        2: w = 32'd64;
        3: w = $urandom_range(0, 80);
        default: w = $urandom();
      endcase
      d = {$urandom(), $urandom()};
      apply(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), w, d);
    end

    // asynchronous reset clears the register
    rst_ni = 1'b0;
    #1;
    check("R8", data_o, 64'd0, illegal_o, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run stalled, got done=0 expected done=1");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule